// File: doc/BRIEF.md
# Audio DAC Soft-Mute and Zero-Detect Controller

This block sits in the sample stream just ahead of a multi-channel audio DAC. It takes one signed sample per channel on each sample strobe and returns a processed sample per channel. It has three jobs. It passes samples through unchanged. Under mute it lets each output decay exponentially toward the signed-zero mid-scale level, with a time constant of about 64 samples. When zero detection is enabled, it clamps every output to exact mid-scale once the input has stayed silent for long enough.

A two-bit mode code, already decoded from an external three-state control pad, picks the behaviour. A force-to-midscale flag and an active-low zero indication tell the output stage that the long-silence condition holds. Release from mute is immediate. The first unmuted strobe outputs the live input, with no ramp.

Top module: `dac_softmute`

## Requirements
- R1: The mode code is decoded as follows: 2'b00 is pass-through, 2'b01 is mute, 2'b10 is zero detect enabled, and 2'b11 behaves exactly like 2'b00.
- R2: In pass-through, and in zero-detect mode before detection, each strobe loads every channel's input into its output. The result is visible after that strobe's clock edge. Channel c occupies bits [c*W +: W] of both `smp_in` and `smp_out`.
- R3: In mute mode, each strobe replaces each output y with y - (y >>> 6), using an arithmetic shift. The decay starts from the last sample passed before mute. Negative values decay up to zero. Positive values below 64 stop changing.
- R4: On the first strobe after mute mode ends, the output equals that strobe's input.
- R5: A counter counts consecutive strobes on which every channel's input is exactly zero. It saturates at 1024. The condition counts as detected on the strobe that brings the count to 1024, and on every later strobe while the count stays there.
- R6: In zero-detect mode, after a strobe on which the condition is detected, `force_mid` is 1, `zero_n` is 0 and every output is exactly 0.
- R7: A strobe with any non-zero channel input resets the counter. After that same strobe, `force_mid` is 0, `zero_n` is 1 and the outputs follow the mode.
- R8: Outside zero-detect mode, `zero_n` stays 1 and `force_mid` stays 0 even when the count is full. The first zero-input strobe in zero-detect mode with a full count asserts both flags.
- R9: Without a strobe, no output or flag changes, whatever the inputs do.
- R10: Synchronous active-high reset sets all outputs to 0, `force_mid` to 0, `zero_n` to 1 and the counter to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | Sample strobe, one cycle per sample period |
| mode_code | input | 2 | Decoded mute-control setting |
| smp_in | input | NCH*W | Signed input samples, channel 0 in the low bits |
| smp_out | output | NCH*W | Processed signed samples |
| force_mid | output | 1 | High while outputs are clamped to mid-scale |
| zero_n | output | 1 | Low while long silence is detected in zero-detect mode |

## Verification
A wrong decay register shows at the port on the very next mute strobe, because every step's value is compared exactly. A stall or a sign error below 64 appears only in the small-value cases, which are driven on purpose. An off-by-one in the silence counter only appears at the 1023rd and 1024th zero strobes, so both edges are checked one strobe apart. A counter that fails to clear shows up immediately in the flags after a single non-zero sample in a long zero run.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

    typedef enum logic [1:0] {
        MC_PASS  = 2'b00,
        MC_MUTE  = 2'b01,
        MC_ZDET  = 2'b10,
        MC_SPARE = 2'b11
    } mute_code_e;

    typedef enum logic [1:0] {
        ACT_PASS  = 2'b00,
        ACT_DECAY = 2'b01,
        ACT_CLAMP = 2'b10
    } chan_act_e;

    typedef struct packed {
        logic      clamp;
        chan_act_e act;
    } path_ctl_t;

    // Mode plus silence status gives the per-channel action for this strobe.
    function automatic path_ctl_t decode_ctl(mute_code_e mc, logic silent_hit);
        path_ctl_t c;
        c.clamp = (mc == MC_ZDET) && silent_hit;
        if (c.clamp)
            c.act = ACT_CLAMP;
        else if (mc == MC_MUTE)
            c.act = ACT_DECAY;
        else
            c.act = ACT_PASS;
        return c;
    endfunction

endpackage

// File: rtl/dsm_zero_det.sv
module dsm_zero_det #(
    parameter int unsigned W     = 24,
    parameter int unsigned NCH   = 2,
    parameter int unsigned LIMIT = 1024
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stb,
    input  logic [NCH*W-1:0]   din,
    output logic               hit_next
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [NCH-1:0] ch_zero;
    logic           all_zero;
    logic [CW-1:0]  cnt_q, cnt_d;

    for (genvar c = 0; c < NCH; c++) begin : g_zchk
        assign ch_zero[c] = (din[c*W +: W] == '0);
    end

    assign all_zero = &ch_zero;

    always_comb begin
        if (!all_zero)
            cnt_d = '0;
        else if (cnt_q == LIM)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + 1'b1;
    end

    assign hit_next = (cnt_d == LIM);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (stb)
            cnt_q <= cnt_d;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIM) else $error("count above limit"); // R5

    AST_NZ_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (stb && (din != '0)) |=> (cnt_q == '0)) else $error("count not cleared"); // R7

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !stb |=> $stable(cnt_q)) else $error("count moved without strobe"); // R9

endmodule

// File: rtl/dsm_chan.sv
module dsm_chan
    import dsm_pkg::*;
#(
    parameter int unsigned W  = 24,
    parameter int unsigned SH = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                stb,
    input  chan_act_e           act,
    input  logic signed [W-1:0] din,
    output logic signed [W-1:0] dout
);
    logic signed [W-1:0] y_q;
    logic signed [W-1:0] step;

    assign step = y_q >>> SH;

    always_ff @(posedge clk) begin
        if (rst)
            y_q <= '0;
        else if (stb) begin
            unique case (act)
                ACT_PASS:  y_q <= din;
                ACT_DECAY: y_q <= y_q - step;
                ACT_CLAMP: y_q <= '0;
                default:   y_q <= din;
            endcase
        end
    end

    assign dout = y_q;

    AST_NO_SIGN_FLIP: assert property (@(posedge clk) disable iff (rst)
        (stb && act == ACT_DECAY) |=> (y_q == '0 || y_q[W-1] == $past(y_q[W-1])))
        else $error("decay crossed zero"); // R3

    AST_CLAMP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (stb && act == ACT_CLAMP) |=> (y_q == '0)) else $error("clamp not zero"); // R6

endmodule

// File: rtl/dac_softmute.sv
module dac_softmute
    import dsm_pkg::*;
#(
    parameter int unsigned W       = 24,
    parameter int unsigned NCH     = 2,
    parameter int unsigned ZLIMIT  = 1024,
    parameter int unsigned DSHIFT  = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_stb,
    input  logic [1:0]       mode_code,
    input  logic [NCH*W-1:0] smp_in,
    output logic [NCH*W-1:0] smp_out,
    output logic             force_mid,
    output logic             zero_n
);
    mute_code_e mc;
    logic       silent_hit;
    path_ctl_t  ctl;
    logic       force_q, zn_q;

    assign mc  = mute_code_e'(mode_code);
    assign ctl = decode_ctl(mc, silent_hit);

    dsm_zero_det #(.W(W), .NCH(NCH), .LIMIT(ZLIMIT)) zdet_i (
        .clk      (clk),
        .rst      (rst),
        .stb      (smp_stb),
        .din      (smp_in),
        .hit_next (silent_hit)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic signed [W-1:0] ch_out;
        dsm_chan #(.W(W), .SH(DSHIFT)) chan_i (
            .clk  (clk),
            .rst  (rst),
            .stb  (smp_stb),
            .act  (ctl.act),
            .din  (smp_in[c*W +: W]),
            .dout (ch_out)
        );
        assign smp_out[c*W +: W] = ch_out;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            force_q <= 1'b0;
            zn_q    <= 1'b1;
        end else if (smp_stb) begin
            force_q <= ctl.clamp;
            zn_q    <= !ctl.clamp;
        end
    end

    assign force_mid = force_q;
    assign zero_n    = zn_q;

    AST_FLAG_PAIR: assert property (@(posedge clk) disable iff (rst)
        force_mid == !zero_n) else $error("flags disagree"); // R6

    AST_FORCE_OUT_ZERO: assert property (@(posedge clk) disable iff (rst)
        force_mid |-> (smp_out == '0)) else $error("forced but not mid-scale"); // R6

    AST_PASS_THRU: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && (mode_code == 2'b00 || mode_code == 2'b11)) |=> (smp_out == $past(smp_in)))
        else $error("pass-through mismatch"); // R2

    AST_NO_ZD_FLAG: assert property (@(posedge clk) disable iff (rst)
        (smp_stb && mode_code != 2'b10) |=> zero_n) else $error("flag outside zero-detect"); // R8

    AST_QUIET: assert property (@(posedge clk) disable iff (rst)
        !smp_stb |=> ($stable(smp_out) && $stable(force_mid) && $stable(zero_n)))
        else $error("change without strobe"); // R9

endmodule

// File: tb/dac_softmute_tb.sv
module dac_softmute_tb_top;
    localparam int unsigned W     = 24;
    localparam int unsigned NCH   = 2;
    localparam time         CLK_P = 10ns;

    typedef struct {
        logic [NCH*W-1:0] d;
        logic             f;
        logic             zn;
        string            tag;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             smp_stb = 1'b0;
    logic [1:0]       mode_code = 2'b00;
    logic [NCH*W-1:0] smp_in = '0;
    logic [NCH*W-1:0] smp_out;
    logic             force_mid, zero_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    exp_t q[$];
    exp_t last;
    logic signed [W-1:0] m_out [NCH];
    int m_cnt;
    logic seen = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    dac_softmute #(.W(W), .NCH(NCH)) dut_i (
        .clk(clk), .rst(rst), .smp_stb(smp_stb), .mode_code(mode_code),
        .smp_in(smp_in), .smp_out(smp_out), .force_mid(force_mid), .zero_n(zero_n)
    );

    function automatic logic [NCH*W-1:0] mk(input logic signed [W-1:0] a,
                                            input logic signed [W-1:0] b);
        return {b, a};
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [NCH*W-1:0] act, input logic [NCH*W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic cmp_all(input exp_t e);
        chk(e.tag, "smp_out", smp_out, e.d);
        chk(e.tag, "force_mid", {{(NCH*W-1){1'b0}}, force_mid}, {{(NCH*W-1){1'b0}}, e.f});
        chk(e.tag, "zero_n", {{(NCH*W-1){1'b0}}, zero_n}, {{(NCH*W-1){1'b0}}, e.zn});
    endtask

    // Reference model built from the requirements.
    task automatic model_reset();
        for (int c = 0; c < NCH; c++) m_out[c] = '0;
        m_cnt   = 0;
        last.d  = '0;
        last.f  = 1'b0;
        last.zn = 1'b1;
        last.tag = "R10";
    endtask

    task automatic strobe(input logic [NCH*W-1:0] d, input logic [1:0] m, input string tag);
        exp_t e;
        bit zd, det;
        @(negedge clk);
        zd    = (m == 2'b10);
        m_cnt = (d == '0) ? ((m_cnt < 1024) ? m_cnt + 1 : 1024) : 0;
        det   = (m_cnt == 1024);
        for (int c = 0; c < NCH; c++) begin
            if (zd && det)       m_out[c] = '0;
            else if (m == 2'b01) m_out[c] = m_out[c] - (m_out[c] >>> 6);
            else                 m_out[c] = d[c*W +: W];
        end
        for (int c = 0; c < NCH; c++) e.d[c*W +: W] = m_out[c];
        e.f   = zd && det;
        e.zn  = !(zd && det);
        e.tag = tag;
        q.push_back(e);
        last = e;
        smp_stb   = 1'b1;
        smp_in    = d;
        mode_code = m;
        @(negedge clk);
        smp_stb = 1'b0;
    endtask

    // Monitor: pops the expected item for each strobe one half cycle after its edge.
    always @(posedge clk) seen <= smp_stb;

    always @(negedge clk) begin
        if (seen) begin
            if (q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: result with no expected item");
            end else begin
                cmp_all(q.pop_front());
            end
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_in    = mk(24'sd777 + i, -24'sd999);
            mode_code = 2'(i);
            #1;
            chk("R9", "idle smp_out", smp_out, last.d);
            chk("R9", "idle zero_n", {{(NCH*W-1){1'b0}}, zero_n}, {{(NCH*W-1){1'b0}}, last.zn});
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        cmp_all(last); // R10 reset state

        // R2 / R1: pass-through in codes 00 and 11
        strobe(mk(24'sd1000, -24'sd2000), 2'b00, "R2");
        strobe(mk(-24'sd8388608, 24'sd8388607), 2'b00, "R2");
        strobe(mk(24'sd12345, 24'sd1), 2'b11, "R1");
        strobe(mk(24'sd1000000, -24'sd1000000), 2'b11, "R1");
        idle(4);

        // R3: decay from the held sample, live input ignored
        for (int i = 0; i < 120; i++)
            strobe(mk(24'sd4242, -24'sd31), 2'b01, "R3");
        idle(3);
        // R4: immediate release
        strobe(mk(24'sd55, -24'sd66), 2'b00, "R4");

        // R3: small values, positive stalls, negative reaches zero
        strobe(mk(24'sd50, -24'sd50), 2'b00, "R2");
        for (int i = 0; i < 60; i++)
            strobe(mk(24'sd9, 24'sd9), 2'b01, "R3");
        strobe(mk(-24'sd7, 24'sd3), 2'b00, "R4");

        // R5 / R6: silence in zero-detect mode
        for (int i = 0; i < 1023; i++)
            strobe('0, 2'b10, "R5");
        strobe('0, 2'b10, "R6");
        for (int i = 0; i < 5; i++)
            strobe('0, 2'b10, "R6");
        idle(3);

        // R7: one non-zero sample clears everything
        strobe(mk(24'sd0, 24'sd1), 2'b10, "R7");
        strobe('0, 2'b10, "R7");

        // R8: long silence outside zero-detect mode
        for (int i = 0; i < 1030; i++)
            strobe('0, (i % 2 == 0) ? 2'b00 : 2'b01, "R8");
        strobe('0, 2'b10, "R8");
        strobe('0, 2'b00, "R8");

        // R10: reset after activity
        strobe(mk(24'sd321, 24'sd654), 2'b00, "R2");
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        @(negedge clk);
        cmp_all(last); // R10
        strobe('0, 2'b10, "R10");

        repeat (3) @(negedge clk);
        if (q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d expected items never produced", q.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule